// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Per-Character Status Queue

This block receives asynchronous serial characters on a single line. It uses a sixteen-times oversampling tick to time the bits. Each character is built up in an internal shift register that the host cannot reach. Once the stop bit has been sampled, the character moves on its own into a small queue. Every slot in that queue holds one character and four status bits for it: parity error, framing error, overrun and break. The host reads the oldest slot through a single read strobe. It sees the character and its status bits together, and a ready flag tells it whether anything is waiting.

The frame can optionally carry an extra multiprocessor bit after the data bits. In that format, one line can be shared by several listeners. Each listener can turn on a wake-up filter, which drops every character whose extra bit is 0, so that only address characters reach the queue. A receiver enable input stops reception at any time. It abandons a partly received character but keeps what is already queued.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rdy` is 0 and the queue is empty.
- R2: A frame has these bits in order: a low start bit, then DATA_BITS data bits sent LSB first, then the multiprocessor bit when `mp_fmt`=1, then the parity bit when `par_en`=1, then one stop bit. Each bit lasts OVS ticks. The start bit is confirmed low half a bit after the falling edge is seen, and every later bit is sampled at its centre.
- R3: The queue holds FIFO_DEPTH characters and releases them oldest first. `rdy` is 1 exactly when the queue is not empty. A `rd` pulse pops the head, and the outputs show the new head from the next clock. A `rd` pulse on an empty queue has no effect.
- R4: With `par_en`=1, `rd_pe` is 1 when the XOR of the data bits and the parity bit differs from `par_odd`. So `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. With `par_en`=0, `rd_pe` is 0.
- R5: `rd_fe` is 1 when the stop bit samples low. After such a frame, the receiver waits for the line to return high before it looks for a new start bit.
- R6: `rd_brk` is 1 when the stop bit is low and every data bit, the multiprocessor bit (if present) and the parity bit (if present) are all 0. Such an entry also has `rd_fe`=1.
- R7: If an accepted character completes while the queue is full and no pop happens in that cycle, the new character is discarded. The newest stored entry then gets `rd_ovr`=1.
- R8: With `mp_fmt`=1 and `wake_en`=1, a character whose multiprocessor bit is 0 creates no entry and sets no overrun, even when the queue is full.
- R9: With `mp_fmt`=0, `wake_en` has no effect, every character is queued, and `rd_mpb` reads 0.
- R10: While `rx_en`=0, no character is queued and any partial frame is abandoned. Entries already in the queue stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Oversampling tick, OVS ticks per bit |
| rx_en | input | 1 | Receiver enable |
| mp_fmt | input | 1 | Frame carries a multiprocessor bit |
| wake_en | input | 1 | Drop characters whose multiprocessor bit is 0 |
| par_en | input | 1 | Frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rxd | input | 1 | Serial input line (asynchronous) |
| rd | input | 1 | Pop the head entry |
| rdy | output | 1 | Queue holds at least one entry |
| rd_data | output | DATA_BITS | Data of the head entry |
| rd_mpb | output | 1 | Multiprocessor bit of the head entry |
| rd_pe | output | 1 | Parity error of the head entry |
| rd_fe | output | 1 | Framing error of the head entry |
| rd_ovr | output | 1 | Overrun flag of the head entry |
| rd_brk | output | 1 | Break flag of the head entry |

## Verification
The bench builds the block with its default parameters: eight data bits, a four-deep queue and 16 ticks per bit. The tick arrives every second clock. With a queue this shallow, a run of five or six frames is enough to reach the full and overrun conditions. A frame also stays short enough to sweep all sixteen combinations of `mp_fmt`, `wake_en`, `par_en` and `par_odd`, with good and corrupted parity and with both values of the multiprocessor bit. The bench also sends frames with a low stop bit, all-zero break frames, and a frame that is cut off by clearing `rx_en`.

// File: rtl/mp_rx_pkg.sv
// Package: types shared by the serial receiver blocks.
// Assumes: nothing beyond the standard language.
package mp_rx_pkg;

    // Receive state machine states
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_BITS,
        S_STOP,
        S_HOLD
    } rx_state_e;

    // Per-character status; the packed order fixes the bit positions in a queue word
    typedef struct packed {
        logic brk;
        logic ovr;
        logic fe;
        logic pe;
    } rx_stat_t;

    localparam int STAT_W   = 4;
    localparam int OVR_POS  = 2;   // position of ovr inside rx_stat_t

endpackage

// File: rtl/mp_rx_shifter.sv
// Module: frame assembler. It finds the start bit, samples the data bits,
// the optional multiprocessor and parity bits and the stop bit at their
// centres, and then emits a one-cycle done pulse with the decoded status.
// Assumes: rx_s is already synchronised. tick pulses OVS times per bit.
// Configuration inputs are held steady while a frame is in flight.
module mp_rx_shifter
    import mp_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_en,
    input  logic                 mp_fmt,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rx_s,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 mpb,
    output rx_stat_t             stat
);
    localparam int TW   = $clog2(OVS);
    localparam int NMAX = DATA_BITS + 2;
    localparam int IW   = $clog2(NMAX + 1);
    localparam logic [TW-1:0] HALF = TW'(OVS / 2 - 1);
    localparam logic [TW-1:0] LAST = TW'(OVS - 1);

    rx_state_e            st;
    logic [TW-1:0]        tcnt;
    logic [IW-1:0]        idx;
    logic [NMAX-1:0]      bits;
    logic [IW-1:0]        nbits;
    logic [DATA_BITS-1:0] d_c;
    logic                 m_c, p_c, pe_c, brk_c;

    // Number of bits after the start bit and before the stop bit
    assign nbits = IW'(DATA_BITS) + IW'(mp_fmt) + IW'(par_en);

    // Decode the collected bits; these are used when the stop bit is sampled
    always_comb begin
        d_c   = bits[DATA_BITS-1:0];
        m_c   = mp_fmt ? bits[DATA_BITS] : 1'b0;
        p_c   = par_en ? (mp_fmt ? bits[DATA_BITS+1] : bits[DATA_BITS]) : 1'b0;
        pe_c  = par_en && ((^d_c ^ p_c) != par_odd);
        brk_c = (d_c == '0) && !m_c && !p_c && !rx_s;
    end

    // Frame sequencing, bit capture and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            tcnt <= '0;
            idx  <= '0;
            bits <= '0;
            done <= 1'b0;
            data <= '0;
            mpb  <= 1'b0;
            stat <= '0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                st   <= S_IDLE;
                tcnt <= '0;
                idx  <= '0;
            end else if (tick) begin
                case (st)
                    S_IDLE: begin
                        if (!rx_s) begin
                            st   <= S_START;
                            tcnt <= '0;
                        end
                    end
                    S_START: begin
                        if (tcnt == HALF) begin
                            tcnt <= '0;
                            if (!rx_s) begin
                                st   <= S_BITS;
                                bits <= '0;
                                idx  <= '0;
                            end else begin
                                st <= S_IDLE;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_BITS: begin
                        if (tcnt == LAST) begin
                            tcnt      <= '0;
                            bits[idx] <= rx_s;
                            if (idx == nbits - IW'(1)) st <= S_STOP;
                            else                       idx <= idx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (tcnt == LAST) begin
                            tcnt     <= '0;
                            done     <= 1'b1;
                            data     <= d_c;
                            mpb      <= m_c;
                            stat.brk <= brk_c;
                            stat.ovr <= 1'b0;
                            stat.fe  <= !rx_s;
                            stat.pe  <= pe_c;
                            st       <= rx_s ? S_IDLE : S_HOLD;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    S_HOLD: begin
                        if (rx_s) st <= S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mp_rx_fifo.sv
// Module: small circular queue of W-bit words. It can set a marker bit in the
// most recently written word. Pushing and popping in the same cycle is allowed.
// Assumes: the caller never pushes when the queue is full unless it also
// pops in that cycle, and never marks an empty queue.
module mp_rx_fifo #(
    parameter int W        = 13,
    parameter int DEPTH    = 4,
    parameter int MARK_BIT = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         mark,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PMAX = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, newest;

    // Slot written last, for the overrun marker
    assign newest = (wr_ptr == '0) ? PMAX : wr_ptr - 1'b1;
    assign head   = mem[rd_ptr];

    // Storage, pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == PMAX) ? '0 : wr_ptr + 1'b1;
            end
            if (mark) mem[newest][MARK_BIT] <= 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PMAX) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mp_uart_rx.sv
// Module: top of the multiprocessor serial receiver. It synchronises the line,
// assembles frames, applies the wake-up filter and queues each character with
// its own status.
// Assumes: baud_tick pulses OVS times per bit, and configuration inputs
// change only while the line is idle.
module mp_uart_rx
    import mp_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int OVS        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 rx_en,
    input  logic                 mp_fmt,
    input  logic                 wake_en,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rxd,
    input  logic                 rd,
    output logic                 rdy,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_mpb,
    output logic                 rd_pe,
    output logic                 rd_fe,
    output logic                 rd_ovr,
    output logic                 rd_brk
);
    localparam int EW       = STAT_W + 1 + DATA_BITS;
    localparam int CW       = $clog2(FIFO_DEPTH + 1);
    localparam int MARK_BIT = DATA_BITS + 1 + OVR_POS;

    logic [1:0]           rx_sync;
    logic                 rx_s;
    logic                 fr_done, fr_mpb;
    logic [DATA_BITS-1:0] fr_data;
    rx_stat_t             fr_stat, hd_stat;
    logic                 accept, full, pop, push, mark;
    logic [EW-1:0]        head;
    logic [CW-1:0]        fifo_count;

    // Two-stage synchroniser for the asynchronous line; idles high
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rxd};
    end
    assign rx_s = rx_sync[1];

    mp_rx_shifter #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_en(rx_en),
        .mp_fmt(mp_fmt), .par_en(par_en), .par_odd(par_odd), .rx_s(rx_s),
        .done(fr_done), .data(fr_data), .mpb(fr_mpb), .stat(fr_stat)
    );

    // Wake-up filter and queue admission
    always_comb begin
        accept = fr_done && !(mp_fmt && wake_en && !fr_mpb);
        full   = (fifo_count == CW'(FIFO_DEPTH));
        pop    = rd && (fifo_count != '0);
        push   = accept && (!full || pop);
        mark   = accept && full && !pop;
    end

    mp_rx_fifo #(.W(EW), .DEPTH(FIFO_DEPTH), .MARK_BIT(MARK_BIT)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push),
        .din({fr_stat, fr_mpb, fr_data}), .mark(mark), .pop(pop),
        .head(head), .count(fifo_count)
    );

    // Present the head entry
    assign hd_stat = rx_stat_t'(head[EW-1 -: STAT_W]);
    assign rd_data = head[DATA_BITS-1:0];
    assign rd_mpb  = head[DATA_BITS];
    assign rd_pe   = hd_stat.pe;
    assign rd_fe   = hd_stat.fe;
    assign rd_ovr  = hd_stat.ovr;
    assign rd_brk  = hd_stat.brk;
    assign rdy     = (fifo_count != '0);
endmodule

// File: rtl/mp_uart_rx_chk.sv
// Module: assertion checker for mp_uart_rx, attached with bind.
// Assumes: connected to the top-level ports and the internal queue signals.
module mp_uart_rx_chk #(
    parameter int DW    = 8,
    parameter int CW    = 3,
    parameter int DEPTH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          rd,
    input logic          rdy,
    input logic [DW-1:0] rd_data,
    input logic          rd_fe,
    input logic          rd_brk,
    input logic          push,
    input logic [CW-1:0] count
);
    // R3: the ready flag drops only after a read
    a_r3_fall_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(rd));

    // R3: the ready flag rises only after a character was queued
    a_r3_rise_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(push));

    // R3: the head data holds while nothing pops it
    a_r3_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !rd) |=> $stable(rd_data));

    // R7: occupancy never exceeds the depth
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R6: a break entry always carries a framing error
    a_r6_break_framed: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && rd_brk) |-> rd_fe);

    // R10: nothing enters the queue while reception is disabled
    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !push);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DW(DATA_BITS), .CW(CW), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd(rd), .rdy(rdy),
    .rd_data(rd_data), .rd_fe(rd_fe), .rd_brk(rd_brk),
    .push(push), .count(fifo_count)
);

// File: tb/mp_uart_rx_test.sv
// Bench: sweeps the frame configurations, error cases, overrun, wake-up
// filtering and receiver disable, and compares against a queue model.
module mp_uart_rx_test;
    localparam int TDIV   = 2;
    localparam int OVS    = 16;
    localparam int BITCLK = OVS * TDIV;

    logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic rx_en = 1'b0, mp_fmt = 1'b0, wake_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic rxd = 1'b1, rd = 1'b0;
    logic rdy, rd_mpb, rd_pe, rd_fe, rd_ovr, rd_brk;
    logic [7:0] rd_data;

    int nvec = 0, nerr = 0;
    bit finished = 0;

    // Reference queue model
    int ex_d[4];
    bit ex_m[4], ex_pe[4], ex_fe[4], ex_ovr[4], ex_brk[4];
    int ex_n = 0;

    always #5 clk = ~clk;
    always @(posedge clk) baud_tick <= ~baud_tick;

    mp_uart_rx uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en),
        .mp_fmt(mp_fmt), .wake_en(wake_en), .par_en(par_en), .par_odd(par_odd),
        .rxd(rxd), .rd(rd), .rdy(rdy), .rd_data(rd_data), .rd_mpb(rd_mpb),
        .rd_pe(rd_pe), .rd_fe(rd_fe), .rd_ovr(rd_ovr), .rd_brk(rd_brk)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold_bit(input logic b);
        rxd = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    // Send raw frame bits and update the model
    task automatic send_bits(input logic [7:0] d, input bit mb, input bit pb, input bit sb);
        bit acc, brk;
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(d[i]);
        if (mp_fmt) hold_bit(mb);
        if (par_en) hold_bit(pb);
        hold_bit(sb);
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        acc = !(mp_fmt && wake_en && !mb);
        brk = (d == 0) && (!mp_fmt || !mb) && (!par_en || !pb) && !sb;
        if (acc) begin
            if (ex_n == 4) ex_ovr[3] = 1;
            else begin
                ex_d[ex_n]   = d;
                ex_m[ex_n]   = mp_fmt ? mb : 0;
                ex_pe[ex_n]  = par_en && ((^d ^ pb) != par_odd);
                ex_fe[ex_n]  = !sb;
                ex_ovr[ex_n] = 0;
                ex_brk[ex_n] = brk;
                ex_n++;
            end
        end
    endtask

    task automatic frame(input logic [7:0] d, input bit mb, input bit badp);
        send_bits(d, mb, (^d) ^ par_odd ^ badp, 1'b1);
    endtask

    // Read everything out and compare with the model
    task automatic drain(input string req);
        for (int i = 0; i < ex_n; i++) begin
            chk({req, " rdy"}, rdy, 1);
            chk({req, " data"}, rd_data, ex_d[i]);
            chk({req, " mpb"}, rd_mpb, ex_m[i]);
            chk({req, " pe"}, rd_pe, ex_pe[i]);
            chk({req, " fe"}, rd_fe, ex_fe[i]);
            chk({req, " ovr"}, rd_ovr, ex_ovr[i]);
            chk({req, " brk"}, rd_brk, ex_brk[i]);
            rd = 1'b1;
            @(negedge clk);
            rd = 1'b0;
        end
        chk({req, " empty"}, rdy, 0);
        ex_n = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdy after reset", rdy, 0);
        rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
        chk("R3 read when empty", rdy, 0);
        rx_en = 1'b1;
        repeat (BITCLK) @(negedge clk);

        // Configuration sweep: R2, R4, R8, R9
        for (int cfg = 0; cfg < 16; cfg++) begin
            mp_fmt = cfg[0]; wake_en = cfg[1]; par_en = cfg[2]; par_odd = cfg[3];
            for (int k = 0; k < 3; k++)
                frame(8'((cfg * 37 + k * 91 + 5) & 255), k[0], k == 1);
            drain("R2_R4_R8_R9 sweep");
        end

        // Framing error then a clean frame: R5
        mp_fmt = 0; wake_en = 0; par_en = 0; par_odd = 0;
        send_bits(8'hA5, 0, 0, 0);
        frame(8'h3C, 0, 0);
        drain("R5 framing");

        // Break with multiprocessor and parity bits present: R6
        mp_fmt = 1; par_en = 1; par_odd = 1;
        send_bits(8'h00, 0, 0, 0);
        par_odd = 0;
        send_bits(8'h00, 0, 0, 0);
        send_bits(8'h00, 1, 0, 0);
        drain("R6 break");

        // Overrun: R7
        mp_fmt = 0; par_en = 0;
        for (int i = 0; i < 6; i++) frame(8'(8'h40 + i), 0, 0);
        drain("R7 overrun");

        // Wake filter on a full queue: R8
        mp_fmt = 1; wake_en = 1;
        for (int i = 0; i < 4; i++) frame(8'(8'h80 + i), 1, 0);
        frame(8'h55, 0, 0);
        frame(8'h66, 0, 0);
        drain("R8 wake full");

        // Receiver disable mid-frame: R10
        mp_fmt = 0; wake_en = 0;
        frame(8'h11, 0, 0);
        hold_bit(1'b0);
        for (int i = 0; i < 3; i++) hold_bit(1'b0);
        rx_en = 1'b0;
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        chk("R10 entry kept while off", rdy, 1);
        chk("R10 head kept while off", rd_data, 8'h11);
        rx_en = 1'b1;
        repeat (BITCLK) @(negedge clk);
        frame(8'h22, 0, 0);
        drain("R10 disable");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule